// File: doc/BRIEF.md
# Memory-Bus to USB FIFO Bridge

This block lets a processor reach an external USB FIFO module through its asynchronous external memory bus. One chip-select window holds three byte-wide peripherals: the FIFO data port, a read-only status byte that reports the FIFO handshake flags, and a scratch register. Software writes the scratch register and reads it back to confirm that the board is present. Bus strobes, chip-select, byte-enable, address, write data and the FIFO flags are brought into the 20 MHz bridge clock through a two-flop pipeline. The bridge turns each bus access to the data port into one read or write pulse of fixed length towards the FIFO.

Software polls the status byte before it moves a byte. It waits while the receive flag is high (nothing to read) or while the transmit flag is high (FIFO busy). The bridge also raises a one-cycle interrupt request each time the receive flag falls, which means new data has arrived. This supports an interrupt-driven receive path in place of polling.

Top module: `membus_fifo_bridge`

## Requirements
- R1: After reset, fifo_rd_pulse, fifo_wr_pulse and irq_pulse are low, and the scratch register reads 0x00.
- R2: Word address 0 is the FIFO data port, 1 is the status byte and 2 is the scratch register. bus_rdata returns the selected byte while bus_cs_n and bus_be_n are both low. Any other address, or a deselected bus, returns 0x00.
- R3: A bus read of address 0 puts fifo_rdata on bus_rdata. It raises fifo_rd_pulse for exactly PULSE_CYC cycles, starting at the third rising clock edge after bus_rd_n falls.
- R4: A bus write to address 0 raises fifo_wr_pulse for exactly PULSE_CYC cycles, starting at the third rising edge after bus_wr_n falls. fifo_wdata holds the written byte from that edge onwards.
- R5: The status byte is, from bit 7 down to bit 0: fifo_txe, fifo_rxf_n, aux_board_id, aux_vcc_out, aux_reset_out, aux_sleep, 0, 0. The two flag bits reflect the flag inputs two clock edges after they change.
- R6: A bus write to address 2 stores the byte in the scratch register, and later reads of address 2 return it (0xAB reads back as 0xAB).
- R7: Writes to address 1, writes to unmapped addresses, and writes made while bus_be_n is high change neither the scratch register nor fifo_wr_pulse.
- R8: Each access gives exactly one pulse, whatever the length of the strobe, and fifo_rd_pulse and fifo_wr_pulse are never high together.
- R9: Each falling edge of fifo_rxf_n gives a one-cycle irq_pulse at the third rising edge after the fall. A rising edge gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz bridge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Active-low chip-select of the bridge window |
| bus_be_n | input | 1 | Active-low enable of the lowest byte lane |
| bus_addr | input | ADDR_W | Word address within the window |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data towards the processor |
| fifo_rxf_n | input | 1 | Low while the FIFO holds received bytes |
| fifo_txe | input | 1 | High while the FIFO cannot accept a byte |
| fifo_rdata | input | 8 | Byte presented by the FIFO |
| fifo_wdata | output | 8 | Byte presented to the FIFO |
| fifo_rd_pulse | output | 1 | Active-high FIFO read pulse |
| fifo_wr_pulse | output | 1 | Active-high FIFO write pulse |
| aux_board_id | input | 1 | Board-ID bit reported in the status byte |
| aux_vcc_out | input | 1 | Supply indication reported in the status byte |
| aux_reset_out | input | 1 | Reset indication reported in the status byte |
| aux_sleep | input | 1 | Sleep indication reported in the status byte |
| irq_pulse | output | 1 | One-cycle interrupt request on new receive data |

## Verification
Every result that passes through the clock domain has a fixed latency. A FIFO pulse, a scratch-register update and an interrupt each appear at the third rising edge after the bus or flag input changes. A status flag shows two edges after it changes, and the read mux answers at once from the raw address. The bench drives inputs on falling edges and samples one time unit after each rising edge. It records the edge number at which each pulse first goes high and how many edges it stays high, then compares both with these fixed counts. This applies to short and long strobes alike.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_FIFO = 2'd1,
        SEL_STAT = 2'd2,
        SEL_TEST = 2'd3
    } sel_e;

    localparam int WADR_FIFO = 0;
    localparam int WADR_STAT = 1;
    localparam int WADR_TEST = 2;

    typedef struct packed {
        logic [DATA_W-1:0] scratch;
        logic [DATA_W-1:0] fwd;
        logic              rxf_prev;
        logic              irq;
    } top_st_t;
endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/bridge_decode.sv
module bridge_decode
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] addr_i,
    output sel_e              sel_o
);
    always_comb begin
        if (addr_i == ADDR_W'(WADR_FIFO)) begin
            sel_o = SEL_FIFO;
        end else if (addr_i == ADDR_W'(WADR_STAT)) begin
            sel_o = SEL_STAT;
        end else if (addr_i == ADDR_W'(WADR_TEST)) begin
            sel_o = SEL_TEST;
        end else begin
            sel_o = SEL_NONE;
        end
    end
endmodule

// File: rtl/bridge_strobe.sv
module bridge_strobe #(
    parameter int PULSE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    output logic start_o,
    output logic pulse_o
);
    localparam int CW = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } strb_st_t;

    strb_st_t st_d, st_q;
    logic     start;

    assign start = act_i && !st_q.act;

    always_comb begin
        st_d     = st_q;
        st_d.act = act_i;
        if (start) begin
            st_d.cnt = CW'(PULSE_CYC);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = start;
    assign pulse_o = (st_q.cnt != '0);

    generate
        if (PULSE_CYC >= 2) begin : g_width_chk
            // R3 / R4: a pulse, once raised, lasts at least two cycles
            assert_pulse_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pulse_o) |=> pulse_o);
        end
    endgenerate

    // R8: a pulse only starts after a fresh activation was seen
    assert_single_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(act_i));
endmodule

// File: rtl/membus_fifo_bridge.sv
module membus_fifo_bridge
    import bridge_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int PULSE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_be_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              fifo_rxf_n,
    input  logic              fifo_txe,
    input  logic [7:0]        fifo_rdata,
    output logic [7:0]        fifo_wdata,
    output logic              fifo_rd_pulse,
    output logic              fifo_wr_pulse,
    input  logic              aux_board_id,
    input  logic              aux_vcc_out,
    input  logic              aux_reset_out,
    input  logic              aux_sleep,
    output logic              irq_pulse
);
    // synchronized vector: {cs_n, rd_n, wr_n, be_n, rxf_n, txe, addr, wdata}
    localparam int CTL_W  = 6;
    localparam int SYNC_W = CTL_W + ADDR_W + DATA_W;
    localparam logic [SYNC_W-1:0] SYNC_RST =
        {5'b11111, 1'b0, {(ADDR_W + DATA_W){1'b0}}};
    localparam int N_CH = 3;
    localparam int CH_RD = 0;
    localparam int CH_WF = 1;
    localparam int CH_WT = 2;

    logic [SYNC_W-1:0] sync_q;
    logic              cs_s, rd_s, wr_s, be_s, rxf_s, txe_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] wdata_s;
    sel_e              sel_raw, sel_s;
    logic [N_CH-1:0]   ch_act, ch_start, ch_pulse;
    top_st_t           st_d, st_q;
    logic [DATA_W-1:0] status_byte;

    bridge_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bus_cs_n, bus_rd_n, bus_wr_n, bus_be_n, fifo_rxf_n, fifo_txe,
                 bus_addr, bus_wdata}),
        .q_o   (sync_q)
    );

    assign {cs_s, rd_s, wr_s, be_s, rxf_s, txe_s, addr_s, wdata_s} = sync_q;

    bridge_decode #(.ADDR_W(ADDR_W)) u_dec_raw (
        .addr_i (bus_addr),
        .sel_o  (sel_raw)
    );

    bridge_decode #(.ADDR_W(ADDR_W)) u_dec_sync (
        .addr_i (addr_s),
        .sel_o  (sel_s)
    );

    // access qualifiers in the clock domain
    always_comb begin
        ch_act        = '0;
        ch_act[CH_RD] = !cs_s && !be_s && !rd_s && (sel_s == SEL_FIFO);
        ch_act[CH_WF] = !cs_s && !be_s && !wr_s && (sel_s == SEL_FIFO);
        ch_act[CH_WT] = !cs_s && !be_s && !wr_s && (sel_s == SEL_TEST);
    end

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            bridge_strobe #(.PULSE_CYC(PULSE_CYC)) u_strobe (
                .clk     (clk),
                .rst_n   (rst_n),
                .act_i   (ch_act[c]),
                .start_o (ch_start[c]),
                .pulse_o (ch_pulse[c])
            );
        end
    endgenerate

    always_comb begin
        st_d          = st_q;
        st_d.rxf_prev = rxf_s;
        st_d.irq      = st_q.rxf_prev && !rxf_s;
        if (ch_start[CH_WT]) begin
            st_d.scratch = wdata_s;
        end
        if (ch_start[CH_WF]) begin
            st_d.fwd = wdata_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{scratch: '0, fwd: '0, rxf_prev: 1'b1, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign status_byte = {txe_s, rxf_s, aux_board_id, aux_vcc_out,
                          aux_reset_out, aux_sleep, 2'b00};

    always_comb begin
        bus_rdata = '0;
        if (!bus_cs_n && !bus_be_n) begin
            case (sel_raw)
                SEL_FIFO: bus_rdata = fifo_rdata;
                SEL_STAT: bus_rdata = status_byte;
                SEL_TEST: bus_rdata = st_q.scratch;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign fifo_rd_pulse = ch_pulse[CH_RD];
    assign fifo_wr_pulse = ch_pulse[CH_WF];
    assign fifo_wdata    = st_q.fwd;
    assign irq_pulse     = st_q.irq;

    // R8: read and write pulses are never driven together
    assert_rdwr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_rd_pulse && fifo_wr_pulse));

    // R9: the interrupt lasts a single cycle
    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R9: an interrupt follows a synchronized low receive flag
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(!rxf_s));

    // R6 / R7: the scratch register moves only after a scratch write
    assert_scratch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.scratch) |-> $past(ch_start[CH_WT]));
endmodule

// File: tb/membus_fifo_bridge_tb_top.sv
module membus_fifo_bridge_tb_top;
    localparam int CLK_PERIOD = 50;
    localparam int AW         = 7;
    localparam int PULSE      = 2;
    localparam int LAT        = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_cs_n, bus_be_n, bus_rd_n, bus_wr_n;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata, bus_rdata;
    logic          fifo_rxf_n, fifo_txe;
    logic [7:0]    fifo_rdata, fifo_wdata;
    logic          fifo_rd_pulse, fifo_wr_pulse;
    logic          aux_board_id, aux_vcc_out, aux_reset_out, aux_sleep;
    logic          irq_pulse;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    membus_fifo_bridge #(.ADDR_W(AW), .PULSE_CYC(PULSE)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_cs_n      (bus_cs_n),
        .bus_be_n      (bus_be_n),
        .bus_addr      (bus_addr),
        .bus_rd_n      (bus_rd_n),
        .bus_wr_n      (bus_wr_n),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .fifo_rxf_n    (fifo_rxf_n),
        .fifo_txe      (fifo_txe),
        .fifo_rdata    (fifo_rdata),
        .fifo_wdata    (fifo_wdata),
        .fifo_rd_pulse (fifo_rd_pulse),
        .fifo_wr_pulse (fifo_wr_pulse),
        .aux_board_id  (aux_board_id),
        .aux_vcc_out   (aux_vcc_out),
        .aux_reset_out (aux_reset_out),
        .aux_sleep     (aux_sleep),
        .irq_pulse     (irq_pulse)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one bus access; records first edge and length of each FIFO pulse
    task automatic access(input bit is_wr, input logic [AW-1:0] a,
                          input logic [7:0] d, input bit be_n, input int hold,
                          output int first_rd, output int n_rd,
                          output int first_wr, output int n_wr,
                          output logic [7:0] rd_byte);
        first_rd = 0; n_rd = 0; first_wr = 0; n_wr = 0; rd_byte = '0;
        @(negedge clk);
        bus_cs_n  = 1'b0;
        bus_be_n  = be_n;
        bus_addr  = a;
        bus_wdata = d;
        if (is_wr) bus_wr_n = 1'b0;
        else       bus_rd_n = 1'b0;
        for (int i = 1; i <= 12; i++) begin
            @(posedge clk);
            #1;
            if (i == 1) rd_byte = bus_rdata;
            if (fifo_rd_pulse) begin
                if (n_rd == 0) first_rd = i;
                n_rd++;
            end
            if (fifo_wr_pulse) begin
                if (n_wr == 0) first_wr = i;
                n_wr++;
            end
            if (i == hold) begin
                bus_rd_n = 1'b1;
                bus_wr_n = 1'b1;
                bus_cs_n = 1'b1;
            end
        end
        bus_be_n = 1'b1;
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_cs_n = 1'b0;
        bus_be_n = 1'b0;
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_cs_n = 1'b1;
        bus_be_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 rd pulse at reset", int'(fifo_rd_pulse), 0);
        check("R1 wr pulse at reset", int'(fifo_wr_pulse), 0);
        check("R1 irq at reset", int'(irq_pulse), 0);
        peek(7'd2, v);
        check("R1 scratch at reset", int'(v), 8'h00);
    endtask

    task automatic t_scratch();
        int fr, nr, fw, nw;
        logic [7:0] rb, v;
        access(1'b1, 7'd2, 8'hAB, 1'b0, 2, fr, nr, fw, nw, rb);
        check("R7 no fifo wr on scratch write", nw, 0);
        peek(7'd2, v);
        check("R6 scratch readback AB", int'(v), 8'hAB);
        access(1'b1, 7'd2, 8'h5C, 1'b0, 2, fr, nr, fw, nw, rb);
        peek(7'd2, v);
        check("R6 scratch readback 5C", int'(v), 8'h5C);
    endtask

    task automatic t_fifo_read();
        int fr, nr, fw, nw;
        logic [7:0] rb;
        fifo_rdata = 8'h3E;
        access(1'b0, 7'd0, 8'h00, 1'b0, 2, fr, nr, fw, nw, rb);
        check("R3 read data", int'(rb), 8'h3E);
        check("R3 rd pulse first edge", fr, LAT);
        check("R3 rd pulse length", nr, PULSE);
        check("R8 no wr during read", nw, 0);
    endtask

    task automatic t_fifo_write();
        int fr, nr, fw, nw;
        logic [7:0] rb;
        access(1'b1, 7'd0, 8'h91, 1'b0, 2, fr, nr, fw, nw, rb);
        check("R4 wr pulse first edge", fw, LAT);
        check("R4 wr pulse length", nw, PULSE);
        check("R4 fifo wdata", int'(fifo_wdata), 8'h91);
        check("R8 no rd during write", nr, 0);
    endtask

    task automatic t_long_strobe();
        int fr, nr, fw, nw;
        logic [7:0] rb;
        access(1'b0, 7'd0, 8'h00, 1'b0, 7, fr, nr, fw, nw, rb);
        check("R8 single rd pulse on long strobe", nr, PULSE);
        access(1'b1, 7'd0, 8'h42, 1'b0, 7, fr, nr, fw, nw, rb);
        check("R8 single wr pulse on long strobe", nw, PULSE);
        check("R4 wdata after long write", int'(fifo_wdata), 8'h42);
    endtask

    task automatic t_status();
        logic [7:0] v;
        @(negedge clk);
        fifo_txe = 1'b1;
        aux_board_id = 1'b1; aux_vcc_out = 1'b0;
        aux_reset_out = 1'b1; aux_sleep = 1'b0;
        repeat (3) @(posedge clk);
        peek(7'd1, v);
        check("R5 status txe busy, rx empty", int'(v), 8'hE8);
        @(negedge clk);
        fifo_txe = 1'b0;
        aux_board_id = 1'b0; aux_vcc_out = 1'b1;
        aux_reset_out = 1'b0; aux_sleep = 1'b1;
        repeat (3) @(posedge clk);
        peek(7'd1, v);
        check("R5 status txe free", int'(v), 8'h54);
    endtask

    task automatic t_ignored();
        int fr, nr, fw, nw;
        logic [7:0] rb, v;
        access(1'b1, 7'd1, 8'h77, 1'b0, 2, fr, nr, fw, nw, rb);
        check("R7 status write no wr pulse", nw, 0);
        peek(7'd2, v);
        check("R7 status write leaves scratch", int'(v), 8'h5C);
        access(1'b1, 7'd5, 8'h66, 1'b0, 2, fr, nr, fw, nw, rb);
        check("R7 unmapped write no wr pulse", nw, 0);
        access(1'b1, 7'd2, 8'h11, 1'b1, 2, fr, nr, fw, nw, rb);
        check("R7 lane-disabled write no wr pulse", nw, 0);
        peek(7'd2, v);
        check("R7 scratch kept after ignored writes", int'(v), 8'h5C);
        access(1'b1, 7'd0, 8'h22, 1'b1, 2, fr, nr, fw, nw, rb);
        check("R7 lane-disabled fifo write no pulse", nw, 0);
        peek(7'd5, v);
        check("R2 unmapped read is zero", int'(v), 8'h00);
        @(negedge clk);
        bus_addr = 7'd2; bus_be_n = 1'b0; bus_cs_n = 1'b1;
        #1;
        check("R2 deselected read is zero", int'(bus_rdata), 8'h00);
        bus_be_n = 1'b1;
    endtask

    task automatic t_irq();
        int first = 0, cnt = 0;
        logic [7:0] v;
        @(negedge clk);
        fifo_rxf_n = 1'b0;
        for (int i = 1; i <= 6; i++) begin
            @(posedge clk);
            #1;
            if (irq_pulse) begin
                if (cnt == 0) first = i;
                cnt++;
            end
        end
        check("R9 irq edge after rxf fall", first, LAT);
        check("R9 irq one cycle", cnt, 1);
        peek(7'd1, v);
        check("R5 status shows rx pending", int'(v[6]), 0);
        cnt = 0;
        @(negedge clk);
        fifo_rxf_n = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            @(posedge clk);
            #1;
            if (irq_pulse) cnt++;
        end
        check("R9 no irq on rxf rise", cnt, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        bus_cs_n = 1'b1; bus_be_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
        bus_addr = '0; bus_wdata = '0;
        fifo_rxf_n = 1'b1; fifo_txe = 1'b0; fifo_rdata = '0;
        aux_board_id = 1'b0; aux_vcc_out = 1'b0;
        aux_reset_out = 1'b0; aux_sleep = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_scratch();
        t_fifo_read();
        t_fifo_write();
        t_long_strobe();
        t_status();
        t_ignored();
        t_irq();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule